// File: doc/BRIEF.md
# Receive Descriptor Fetch Controller

This block controls the receive side of a descriptor-driven DMA engine. Software programs a list base address, then issues a start command. The controller copies the base into a current-descriptor pointer and reads the descriptor there through a simple request/response memory port. It then checks the ownership flag in the first descriptor word. If the DMA owns the descriptor, the engine runs. If the host still owns it, the engine suspends and waits for software.

Software wakes a suspended engine by writing the poll strobe, with any data value. This fetches the same descriptor again. If the host still owns it, the engine quietly suspends again and raises no buffer-unavailable status. If the DMA now owns it, the engine resumes and reports the resumption with a one-cycle pulse. The base register accepts writes only while the engine is stopped. Its low address bits are forced to zero to match the configured bus width.

Top module: `rx_desc_fetch`

## Requirements
- R1: After reset, `baseAddr` and `curDescPtr` are zero, `runState` is Stopped (2'b00), and `memReqValid` is low. `runState` encodes Stopped=00, Running=01, Suspended=10, Fetching=11.
- R2: In Stopped, a register write with `regSel`=2'b00 stores `regWrData` in the base register. The low address bits are read back as zero: 2 bits for a 32-bit bus, 3 bits for a 64-bit bus and 4 bits for a 128-bit bus.
- R3: A base write (`regSel`=2'b00) in any state other than Stopped leaves `baseAddr` unchanged.
- R4: A start command (`regSel`=2'b01) in Stopped loads `curDescPtr` from the base register and enters Fetching. `memReqValid` is raised with `memReqAddr`=`curDescPtr`, and both are held stable until `memReqReady` accepts the request.
- R5: On the response to a fetch that start issued, an ownership bit of 1 (DMA owns) leads to Running. An ownership bit of 0 (host owns) leads to Suspended, with `bufUnavail` pulsing high for exactly the first Suspended cycle.
- R6: A poll write (`regSel`=2'b11, any data) in Suspended re-fetches the descriptor at `curDescPtr`. A host-owned result returns to Suspended without a `bufUnavail` pulse. A DMA-owned result enters Running, with `resumePulse` high for exactly the first Running cycle.
- R7: A poll write in Stopped or Running issues no memory request and leaves `runState` unchanged.
- R8: A stop command (`regSel`=2'b10) moves Running or Suspended to Stopped at the next edge. During Fetching, the engine reaches Stopped only once the outstanding response has been consumed.
- R9: A start command outside Stopped is ignored. It issues no request and leaves `runState` and `curDescPtr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Write target: 00 base, 01 start, 10 stop, 11 poll |
| regWrData | input | ADDR_W | Write data (used only by base writes) |
| baseAddr | output | ADDR_W | Base register read-back, with alignment bits zero |
| curDescPtr | output | ADDR_W | Current descriptor pointer |
| runState | output | 2 | Engine state code |
| memReqValid | output | 1 | Descriptor read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Descriptor read address |
| memRspValid | input | 1 | Descriptor response valid |
| memRspOwn | input | 1 | Ownership bit of descriptor word 0 (its bit 31): 1 DMA, 0 host |
| resumePulse | output | 1 | One-cycle pulse on each Suspended-to-Running resumption |
| bufUnavail | output | 1 | One-cycle pulse when a start fetch finds a host-owned descriptor |

## Verification
The checker watches several properties on every cycle:
- the alignment bits of the base register stay zero;
- the base register stays frozen outside Stopped;
- a pending request is held with a stable address;
- no request appears in Stopped;
- each status pulse coincides with the state it reports.

Other behaviours depend on history and can only be shown by the bench's scenarios:
- a start fetch raises the unavailable status while a poll fetch never does;
- a stop issued during an outstanding read waits for the response;
- polls and starts in the wrong state are absorbed.

The bench also sweeps base-write values and checks the masked read-back arithmetically.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'b00,
    ST_RUN   = 2'b01,
    ST_SUSP  = 2'b10,
    ST_FETCH = 2'b11
  } rdf_state_e;

  localparam logic [1:0] SEL_BASE  = 2'b00;
  localparam logic [1:0] SEL_START = 2'b01;
  localparam logic [1:0] SEL_STOP  = 2'b10;
  localparam logic [1:0] SEL_POLL  = 2'b11;

  typedef struct packed {
    logic baseWr;
    logic ptrLoad;
  } rdf_strobe_t;
endpackage

// File: rtl/rdf_ctrl.sv
module rdf_ctrl
  import rdf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspOwn,
  output rdf_strobe_t strobe,
  output rdf_state_e  state,
  output logic        reqOut,
  output logic        resumePulse,
  output logic        bufUnavail
);
  logic fromPoll;
  logic stopPend;
  logic cmdStart, cmdStop, cmdPoll, rspTake;

  assign cmdStart = regWrEn && (regSel == SEL_START);
  assign cmdStop  = regWrEn && (regSel == SEL_STOP);
  assign cmdPoll  = regWrEn && (regSel == SEL_POLL);
  assign rspTake  = (state == ST_FETCH) && !reqOut && memRspValid;

  always_comb begin
    strobe.baseWr  = regWrEn && (regSel == SEL_BASE) && (state == ST_STOP);
    strobe.ptrLoad = cmdStart && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_STOP;
      reqOut      <= 1'b0;
      fromPoll    <= 1'b0;
      stopPend    <= 1'b0;
      resumePulse <= 1'b0;
      bufUnavail  <= 1'b0;
    end else begin
      resumePulse <= 1'b0;
      bufUnavail  <= 1'b0;
      case (state)
        ST_STOP: if (cmdStart) begin
          state    <= ST_FETCH;
          reqOut   <= 1'b1;
          fromPoll <= 1'b0;
          stopPend <= 1'b0;
        end
        ST_RUN: if (cmdStop) state <= ST_STOP;
        ST_SUSP: begin
          if (cmdStop) begin
            state <= ST_STOP;
          end else if (cmdPoll) begin
            state    <= ST_FETCH;
            reqOut   <= 1'b1;
            fromPoll <= 1'b1;
            stopPend <= 1'b0;
          end
        end
        default: begin
          if (cmdStop) stopPend <= 1'b1;
          if (reqOut && memReqReady) reqOut <= 1'b0;
          if (rspTake) begin
            if (stopPend || cmdStop) begin
              state <= ST_STOP;
            end else if (memRspOwn) begin
              state       <= ST_RUN;
              resumePulse <= fromPoll;
            end else begin
              state      <= ST_SUSP;
              bufUnavail <= !fromPoll;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rdf_dpath.sv
module rdf_dpath
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdf_strobe_t       strobe,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] baseReg,
  output logic [ADDR_W-1:0] curPtr
);
  localparam int ALIGN_BITS = $clog2(BUS_W / 8);
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    {{(ADDR_W - ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      curPtr  <= '0;
    end else begin
      if (strobe.baseWr)  baseReg <= regWrData & KEEP_MASK;
      if (strobe.ptrLoad) curPtr  <= baseReg;
    end
  end
endmodule

// File: rtl/rx_desc_fetch.sv
module rx_desc_fetch
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] curDescPtr,
  output logic [1:0]        runState,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic              memRspOwn,
  output logic              resumePulse,
  output logic              bufUnavail
);
  rdf_strobe_t strobe;
  rdf_state_e  state;

  rdf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspOwn(memRspOwn),
    .strobe(strobe), .state(state), .reqOut(memReqValid),
    .resumePulse(resumePulse), .bufUnavail(bufUnavail)
  );

  rdf_dpath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .baseReg(baseAddr), .curPtr(curDescPtr)
  );

  assign runState   = state;
  assign memReqAddr = curDescPtr;
endmodule

// File: rtl/rdf_chk.sv
module rdf_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [1:0]        runState,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              resumePulse,
  input logic              bufUnavail
);
  localparam int ALIGN_BITS = $clog2(BUS_W / 8);

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseAddr[ALIGN_BITS-1:0] == '0);

  // R3
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runState != 2'b00) |=> $stable(baseAddr));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'b00) |-> !memReqValid);

  // R5
  unavail_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavail |-> (runState == 2'b10));

  // R6
  resume_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> (runState == 2'b01));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resumePulse && bufUnavail));
endmodule

bind rx_desc_fetch rdf_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_rdf_chk (
  .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .runState(runState),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .resumePulse(resumePulse), .bufUnavail(bufUnavail)
);

// File: tb/rx_desc_fetch_bench.sv
`timescale 1ns/1ps
module rx_desc_fetch_bench;
  localparam int ADDR_W = 32;
  localparam int BUS_W  = 32;
  localparam int ALIGN  = $clog2(BUS_W / 8);
  localparam logic [ADDR_W-1:0] KEEP = ~((ADDR_W'(1) << ALIGN) - 1);

  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [1:0] regSel = 0;
  logic [ADDR_W-1:0] regWrData = 0;
  logic [ADDR_W-1:0] baseAddr, curDescPtr, memReqAddr;
  logic [1:0] runState;
  logic memReqValid, memReqReady, memRspValid, memRspOwn, resumePulse, bufUnavail;

  int passCnt = 0, failCnt = 0, cycles = 0;
  int reqCnt = 0, resumeCnt = 0, unavailCnt = 0;
  logic rdy = 1, ownVal = 1;
  int rspDelay = 0, cnt = 0;
  logic pend = 0;

  always #2 clk = ~clk;

  rx_desc_fetch #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_rx_desc_fetch (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .baseAddr(baseAddr), .curDescPtr(curDescPtr), .runState(runState),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspOwn(memRspOwn),
    .resumePulse(resumePulse), .bufUnavail(bufUnavail)
  );

  assign memReqReady = rdy;

  initial begin memRspValid = 0; memRspOwn = 0; end
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRspValid) memRspValid <= 0;
    if (memReqValid && memReqReady) begin
      pend <= 1; cnt <= rspDelay; reqCnt <= reqCnt + 1;
    end else if (pend) begin
      if (cnt == 0) begin memRspValid <= 1; memRspOwn <= ownVal; pend <= 0; end
      else cnt <= cnt - 1;
    end
    if (resumePulse) resumeCnt <= resumeCnt + 1;
    if (bufUnavail) unavailCnt <= unavailCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [ADDR_W-1:0] d);
    @(negedge clk); regWrEn = 1; regSel = sel; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40 && runState == 2'b11; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    if (cycles > 0) ;
  end

  always @(negedge clk) if (cycles > 20000) begin
    failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    int r0, u0, q0;
    logic [ADDR_W-1:0] b0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(baseAddr == 0 && curDescPtr == 0, "R1 ptrs", baseAddr | curDescPtr, 0);
    chk(runState == 2'b00 && !memReqValid, "R1 state", {runState, memReqValid}, 0);

    // R2 sweep
    for (int i = 0; i < 24; i++) begin
      logic [ADDR_W-1:0] v;
      v = 32'h9E37_79B9 * i + i;
      regWrite(2'b00, v);
      chk(baseAddr == (v & KEEP), "R2 align", baseAddr, v & KEEP);
    end

    regWrite(2'b00, 32'h0000_1003);
    ownVal = 1; r0 = resumeCnt; u0 = unavailCnt;
    regWrite(2'b01, 0);
    // R4
    chk(runState == 2'b11 && memReqValid, "R4 fetch", {runState, memReqValid}, 3'b111);
    chk(memReqAddr == 32'h1000 && curDescPtr == 32'h1000, "R4 addr", memReqAddr, 32'h1000);
    settle();
    // R5
    chk(runState == 2'b01, "R5 run", runState, 2'b01);
    chk(resumeCnt == r0 && unavailCnt == u0, "R5 no pulse", resumeCnt + unavailCnt, r0 + u0);

    // R3
    regWrite(2'b00, 32'hABCD_0000);
    chk(baseAddr == 32'h1000, "R3 ignored", baseAddr, 32'h1000);
    // R7 poll in Running
    q0 = reqCnt;
    regWrite(2'b11, 32'h5);
    repeat (3) @(negedge clk);
    chk(reqCnt == q0 && runState == 2'b01, "R7 run poll", reqCnt, q0);
    // R9
    regWrite(2'b01, 0);
    repeat (3) @(negedge clk);
    chk(reqCnt == q0 && runState == 2'b01 && curDescPtr == 32'h1000, "R9 start", reqCnt, q0);

    // R8
    regWrite(2'b10, 0);
    chk(runState == 2'b00, "R8 run stop", runState, 0);
    // R7 poll in Stopped
    regWrite(2'b11, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    chk(reqCnt == q0 && runState == 2'b00, "R7 stop poll", reqCnt, q0);

    // R5 host-owned start
    regWrite(2'b00, 32'h0000_2000);
    ownVal = 0; u0 = unavailCnt; r0 = resumeCnt;
    regWrite(2'b01, 0);
    settle();
    chk(runState == 2'b10, "R5 susp", runState, 2'b10);
    chk(unavailCnt == u0 + 1, "R5 unavail", unavailCnt, u0 + 1);

    // R6 poll host-owned
    q0 = reqCnt;
    regWrite(2'b11, 32'h0);
    settle();
    chk(reqCnt == q0 + 1 && runState == 2'b10, "R6 refetch", reqCnt, q0 + 1);
    chk(unavailCnt == u0 + 1 && resumeCnt == r0, "R6 no unavail", unavailCnt, u0 + 1);
    // R6 poll DMA-owned
    ownVal = 1;
    regWrite(2'b11, 32'h1234);
    settle();
    chk(runState == 2'b01, "R6 resume state", runState, 2'b01);
    chk(resumeCnt == r0 + 1, "R6 resume pulse", resumeCnt, r0 + 1);

    // R4 hold + R8 stop during fetch
    regWrite(2'b10, 0);
    regWrite(2'b00, 32'h0000_3004);
    rdy = 0; rspDelay = 4; b0 = 32'h3004;
    regWrite(2'b01, 0);
    repeat (5) @(negedge clk);
    chk(memReqValid && memReqAddr == b0 && runState == 2'b11, "R4 hold", memReqAddr, b0);
    rdy = 1;
    @(negedge clk);
    regWrite(2'b10, 0);
    chk(runState == 2'b11, "R8 wait rsp", runState, 2'b11);
    settle();
    chk(runState == 2'b00, "R8 fetch stop", runState, 0);
    rspDelay = 0;

    // R8 stop from Suspended
    ownVal = 0;
    regWrite(2'b01, 0);
    settle();
    regWrite(2'b10, 0);
    chk(runState == 2'b00, "R8 susp stop", runState, 0);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule